// File: doc/BRIEF.md
# SPI Serial-Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select line for one SPI master packet, and tells a data shifter when to move and capture bits. Each phase of the packet has its own length, given in core-clock cycles as a count minus one: the select setup before the first clock edge, the high and low halves of every bit, the select hold after the last edge, and the deselected gap that must pass before another packet may begin.

A sequencer raises `start` while the block is idle. The block then runs setup, the bit periods, hold and gap in that order. During the packet it emits one-cycle `sampleEn` and `shiftEn` pulses at the proper clock edges and a `byteStrobe` pulse after every eighth bit. It raises `done` for one cycle at the end of the gap. Clock polarity, clock phase, chip-select polarity and an alternate sampling edge are selected by static control inputs. These inputs and the timing fields must be held steady while `busy` is high.

Top module: `spi_phase_timer`

## Requirements
- R1: Out of reset and whenever `busy` is low, `sck` equals `cpol`, `csOut` is inactive and `sampleEn`, `shiftEn`, `byteStrobe` and `done` are low.
- R2: A `start` seen at a clock edge while idle makes `busy` high and `csOut` active from the next cycle on. `sck` stays at `cpol` for `cfgSetup`+1 cycles before the first bit.
- R3: Every bit period first holds `sck` at `cpol` and then at its inverse. A half with `sck` high lasts `cfgHigh`+1 cycles, and a half with `sck` low lasts `cfgLow`+1 cycles.
- R4: A packet carries (`cfgLen`+1)*8 bit periods back to back.
- R5: After the last bit, `sck` returns to `cpol` and `csOut` stays active for `cfgHold`+1 cycles. Then `csOut` is inactive for `cfgIdle`+1 cycles while `busy` stays high.
- R6: `done` is high for exactly one cycle, the last cycle of the gap. `busy` is low in the following cycle.
- R7: `csOut` is active high when `csActiveHigh` is 1 and active low when it is 0.
- R8: The leading edge of a bit is the cycle `sck` first shows the inverse of `cpol`. The trailing edge is the cycle it first shows `cpol` again. `sampleEn` pulses on every trailing edge when `cpha` XOR `sampleAlt` is 1, and on every leading edge otherwise.
- R9: With `cpha`=1, `shiftEn` pulses on every leading edge. With `cpha`=0, it pulses on every trailing edge except the one that follows the last bit.
- R10: `byteStrobe` pulses on the trailing edge that follows bits 8, 16, 24 and so on.
- R11: `start` has no effect while `busy` is high. A packet is never shortened or restarted by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a packet when idle |
| cfgHigh | input | CNT_W | SCK high half length minus one |
| cfgLow | input | CNT_W | SCK low half length minus one |
| cfgSetup | input | CNT_W | Select setup length minus one |
| cfgHold | input | CNT_W | Select hold length minus one |
| cfgIdle | input | CNT_W | Deselected gap length minus one |
| cfgLen | input | LEN_W | Packet length in bytes minus one |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| csActiveHigh | input | 1 | Chip-select polarity |
| sampleAlt | input | 1 | Move sampling to the opposite edge |
| sck | output | 1 | Serial clock |
| csOut | output | 1 | Chip select |
| sampleEn | output | 1 | Capture strobe for the receive shifter |
| shiftEn | output | 1 | Advance strobe for the transmit shifter |
| byteStrobe | output | 1 | A byte has completed |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
A miscounted phase counter shows up as a half period of the wrong length. This appears on `sck` within the same bit, and every later edge pulse lands in the wrong cycle. A bit counter that is off by one adds or drops a full period before hold, so `csOut` releases late or early, and `byteStrobe` drifts from the eighth trailing edge. A state machine that loses its place shows `sck` off its idle level while `busy` is low, or `done` at a cycle other than the end of the gap. The bench compares every output against an arithmetic schedule in every cycle, so each of these faults is reported in the first cycle it appears.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_FIRST,   // half at the clock idle level
    PH_SECOND,  // half at the inverted level
    PH_HOLD,
    PH_GAP
  } phase_t;

  typedef enum logic [2:0] {
    LD_SETUP,
    LD_FIRST,
    LD_SECOND,
    LD_HOLD,
    LD_GAP
  } load_t;

  typedef struct packed {
    logic  load;
    load_t loadSel;
    logic  bitInc;
    logic  bitClr;
  } strobe_t;

endpackage

// File: rtl/spi_phase_count.sv
module spi_phase_count
  import spi_phase_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LEN_W     = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ctl,
  input  logic             cpol,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgIdle,
  input  logic [LEN_W-1:0] cfgLen,
  output logic             cntZero,
  output logic             firstBit,
  output logic             lastBit,
  output logic             byteEdge
);

  localparam int SUB_W = $clog2(BYTE_BITS);
  localparam int IDX_W = LEN_W + SUB_W;

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] loadVal;
  logic [IDX_W-1:0] bitIdx;

  // The half at the idle level takes the field of that level.
  always_comb begin
    unique case (ctl.loadSel)
      LD_SETUP:  loadVal = cfgSetup;
      LD_FIRST:  loadVal = cpol ? cfgHigh : cfgLow;
      LD_SECOND: loadVal = cpol ? cfgLow : cfgHigh;
      LD_HOLD:   loadVal = cfgHold;
      LD_GAP:    loadVal = cfgIdle;
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.load) begin
      phaseCnt <= loadVal;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  // Counts the bits completed so far in the packet.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (ctl.bitClr) begin
      bitIdx <= '0;
    end else if (ctl.bitInc) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  assign cntZero  = (phaseCnt == '0);
  assign firstBit = (bitIdx == '0);
  assign lastBit  = (bitIdx == {cfgLen, {SUB_W{1'b1}}});
  assign byteEdge = (bitIdx[SUB_W-1:0] == '0);

endmodule

// File: rtl/spi_phase_ctrl.sv
module spi_phase_ctrl
  import spi_phase_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cntZero,
  input  logic    firstBit,
  input  logic    lastBit,
  input  logic    byteEdge,
  input  logic    cpol,
  input  logic    cpha,
  input  logic    csActiveHigh,
  input  logic    sampleAlt,
  output strobe_t ctl,
  output logic    sck,
  output logic    csOut,
  output logic    sampleEn,
  output logic    shiftEn,
  output logic    byteStrobe,
  output logic    busy,
  output logic    done
);

  phase_t state, nxt;
  logic   firstCyc;
  logic   leadEdge, trailEdge, csAct;

  always_comb begin
    nxt         = state;
    ctl.load    = 1'b0;
    ctl.loadSel = LD_SETUP;
    ctl.bitInc  = 1'b0;
    ctl.bitClr  = 1'b0;
    unique case (state)
      PH_IDLE: if (start) begin
        nxt        = PH_SETUP;
        ctl.load   = 1'b1;
        ctl.bitClr = 1'b1;
      end
      PH_SETUP: if (cntZero) begin
        nxt         = PH_FIRST;
        ctl.load    = 1'b1;
        ctl.loadSel = LD_FIRST;
      end
      PH_FIRST: if (cntZero) begin
        nxt         = PH_SECOND;
        ctl.load    = 1'b1;
        ctl.loadSel = LD_SECOND;
      end
      PH_SECOND: if (cntZero) begin
        ctl.load    = 1'b1;
        ctl.bitInc  = 1'b1;
        nxt         = lastBit ? PH_HOLD : PH_FIRST;
        ctl.loadSel = lastBit ? LD_HOLD : LD_FIRST;
      end
      PH_HOLD: if (cntZero) begin
        nxt         = PH_GAP;
        ctl.load    = 1'b1;
        ctl.loadSel = LD_GAP;
      end
      PH_GAP: if (cntZero) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      firstCyc <= 1'b0;
    end else begin
      state    <= nxt;
      firstCyc <= (nxt != state);
    end
  end

  assign leadEdge  = firstCyc && (state == PH_SECOND);
  assign trailEdge = firstCyc && ((state == PH_HOLD) ||
                                  ((state == PH_FIRST) && !firstBit));
  assign csAct     = (state == PH_SETUP) || (state == PH_FIRST) ||
                     (state == PH_SECOND) || (state == PH_HOLD);

  assign sck        = (state == PH_SECOND) ? ~cpol : cpol;
  assign csOut      = csAct ? csActiveHigh : ~csActiveHigh;
  assign sampleEn   = (cpha ^ sampleAlt) ? trailEdge : leadEdge;
  assign shiftEn    = cpha ? leadEdge : (trailEdge && (state == PH_FIRST));
  assign byteStrobe = trailEdge && byteEdge;
  assign busy       = (state != PH_IDLE);
  assign done       = (state == PH_GAP) && cntZero;

endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer
  import spi_phase_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgIdle,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             csActiveHigh,
  input  logic             sampleAlt,
  output logic             sck,
  output logic             csOut,
  output logic             sampleEn,
  output logic             shiftEn,
  output logic             byteStrobe,
  output logic             busy,
  output logic             done
);

  strobe_t ctl;
  logic    cntZero, firstBit, lastBit, byteEdge;

  spi_phase_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cntZero(cntZero), .firstBit(firstBit), .lastBit(lastBit), .byteEdge(byteEdge),
    .cpol(cpol), .cpha(cpha), .csActiveHigh(csActiveHigh), .sampleAlt(sampleAlt),
    .ctl(ctl), .sck(sck), .csOut(csOut), .sampleEn(sampleEn), .shiftEn(shiftEn),
    .byteStrobe(byteStrobe), .busy(busy), .done(done)
  );

  spi_phase_count #(.CNT_W(CNT_W), .LEN_W(LEN_W), .BYTE_BITS(8)) uCount (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpol(cpol),
    .cfgHigh(cfgHigh), .cfgLow(cfgLow), .cfgSetup(cfgSetup),
    .cfgHold(cfgHold), .cfgIdle(cfgIdle), .cfgLen(cfgLen),
    .cntZero(cntZero), .firstBit(firstBit), .lastBit(lastBit), .byteEdge(byteEdge)
  );

endmodule

// File: rtl/spi_phase_checker.sv
module spi_phase_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic cpol,
  input logic csActiveHigh,
  input logic sck,
  input logic csOut,
  input logic sampleEn,
  input logic busy,
  input logic done
);

  p_idle_sck_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sck == cpol);

  p_idle_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csOut != csActiveHigh);

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && csOut == csActiveHigh));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_sample_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> sck != $past(sck));

endmodule

bind spi_phase_timer spi_phase_checker uChk (
  .clk(clk), .rstN(rstN), .start(start), .cpol(cpol),
  .csActiveHigh(csActiveHigh), .sck(sck), .csOut(csOut),
  .sampleEn(sampleEn), .busy(busy), .done(done)
);

// File: tb/spi_phase_timer_test.sv
`timescale 1ns/1ps
module spi_phase_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cfgHigh = '0, cfgLow = '0, cfgSetup = '0, cfgHold = '0, cfgIdle = '0;
  logic [3:0] cfgLen = '0;
  logic       cpol = 1'b0, cpha = 1'b0, csActiveHigh = 1'b0, sampleAlt = 1'b0;
  logic       sck, csOut, sampleEn, shiftEn, byteStrobe, busy, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_phase_timer uut (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgHigh(cfgHigh), .cfgLow(cfgLow), .cfgSetup(cfgSetup),
    .cfgHold(cfgHold), .cfgIdle(cfgIdle), .cfgLen(cfgLen),
    .cpol(cpol), .cpha(cpha), .csActiveHigh(csActiveHigh), .sampleAlt(sampleAlt),
    .sck(sck), .csOut(csOut), .sampleEn(sampleEn), .shiftEn(shiftEn),
    .byteStrobe(byteStrobe), .busy(busy), .done(done)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_packet(input int S, input int H, input int L, input int D,
                            input int I, input int ln, input int mode);
    int first, second, per, nb, body, total, leads;
    cfgSetup = 8'(S); cfgHigh = 8'(H); cfgLow = 8'(L);
    cfgHold = 8'(D); cfgIdle = 8'(I); cfgLen = 4'(ln);
    cpol = mode[0]; cpha = mode[1]; csActiveHigh = mode[2]; sampleAlt = mode[3];
    first  = cpol ? H + 1 : L + 1;
    second = cpol ? L + 1 : H + 1;
    per    = first + second;
    nb     = (ln + 1) * 8;
    body   = nb * per;
    total  = (S + 1) + body + (D + 1) + (I + 1);
    leads  = 0;
    start  = 1'b1;
    @(negedge clk);
    for (int t = 0; t <= total; t++) begin
      logic eSck, eCs, eLead, eTrail, eInBody, eByte, eDone, eBusy;
      int u;
      eSck = cpol; eCs = 1'b0; eLead = 0; eTrail = 0; eInBody = 0;
      eByte = 0; eDone = 0; eBusy = (t < total);
      u = t - (S + 1);
      if (t < S + 1) begin
        eCs = 1'b1;                                   // R2 setup
      end else if (u < body) begin
        int b, r;
        b = u / per; r = u % per;
        eCs = 1'b1; eInBody = 1;
        eSck = (r < first) ? cpol : ~cpol;            // R3
        eLead = (r == first);
        eTrail = (r == 0) && (b > 0);
        eByte = eTrail && (b % 8 == 0);               // R10
      end else if (u < body + D + 1) begin
        eCs = 1'b1;                                   // R5 hold
        eTrail = (u == body);
        eByte = eTrail;
      end else if (t < total) begin
        eDone = (t == total - 1);                     // R6
      end
      check(sck, eSck, "R3 sck", t);
      check(csOut, eCs ? csActiveHigh : ~csActiveHigh, "R7 csOut", t);
      check(sampleEn, (cpha ^ sampleAlt) ? eTrail : eLead, "R8 sampleEn", t);
      check(shiftEn, cpha ? eLead : (eTrail && eInBody), "R9 shiftEn", t);
      check(byteStrobe, eByte, "R10 byteStrobe", t);
      check(done, eDone, "R6 done", t);
      check(busy, eBusy, "R11 busy", t);
      if (sampleEn === ((cpha ^ sampleAlt) ? 1'b0 : 1'b1) && sampleEn) leads++;
      if (t == total - 1) start = 1'b0;   // held high until now: R11
      if (t < total) @(negedge clk);
    end
    // R4: count of leading-edge samples equals bit count when sampling leads
    if (!(cpha ^ sampleAlt)) check(leads == nb, 1'b1, "R4 bit count", total);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset and idle state
    check(sck, 1'b0, "R1 sck reset", 0);
    check(csOut, 1'b1, "R1 csOut reset", 0);
    check(busy, 1'b0, "R1 busy reset", 0);
    check(done, 1'b0, "R1 done reset", 0);
    rstN = 1'b1;
    @(negedge clk);
    cpol = 1'b1; csActiveHigh = 1'b1;
    #1;
    check(sck, 1'b1, "R1 idle sck follows cpol", 0);
    check(csOut, 1'b0, "R1 idle cs inactive", 0);
    check(sampleEn | shiftEn | byteStrobe, 1'b0, "R1 idle pulses", 0);
    @(negedge clk);
    for (int mode = 0; mode < 16; mode++)
      for (int hl = 0; hl < 4; hl++)
        for (int ln = 0; ln < 2; ln++) begin
          int idx;
          idx = mode * 8 + hl * 2 + ln;
          run_packet(idx % 3, (hl & 1) * 2, (hl >> 1) * 2,
                     (idx / 3) % 3, (idx / 2) % 4, ln, mode);
        end
    finish_run();
  end

endmodule